// File: doc/BRIEF.md
# Interleaved Memory Bank Conflict Arbiter

This block decides, every clock, which of several memory request ports may start an access into a 32-way interleaved memory. Each port presents the low bits of a word address and a tag naming the processor that owns the port. The interleave field selects one of 32 banks. Its upper two bits name one of four subsections, and its top bit names one of two sections. Three kinds of conflict are checked in a fixed order. Same-cycle section collisions between ports of one processor come first. Next come subsection reservations left by a sibling port of the same processor. Bank conflicts come last, and they apply to ports of any processor. Bank conflicts are reported in two forms: the bank is still recovering from an earlier access, or another port asks for the bank in the same cycle.

The result is purely combinational from the current requests and the recovery timers. A port that is refused keeps its request unchanged until it is granted. Each bank needs five clocks per access. Because of this, one port stepping through memory with a constant stride loses bandwidth only when the stride maps onto fewer than five distinct banks.

Top module: `bank_conflict_arbiter`

## Requirements
- R1: The bank index is address bits [4:0], the subsection index is bits [4:3] and the section index is bit [4]; higher address bits play no part in any decision.
- R2: When two or more requesting ports with the same processor tag ask for the same section in one cycle, only the lowest-numbered of them can proceed; every other one is refused with code 01.
- R3: When a port of a processor is granted, that subsection is reserved for 4 clocks against the other ports of that processor. Such a port is refused with code 01 only for a same-cycle section clash, otherwise with code 10, and it is granted in the 5th cycle after the reserving grant.
- R4: When a port is both in a reserved subsection and aimed at a busy bank, it reports code 10 (subsection) rather than 11.
- R5: A bank granted in cycle t refuses every port of every processor in cycles t+1 to t+4 with code 11 and the busy flag at 1, and it can be granted again in cycle t+5.
- R6: When ports ask for the same idle bank in one cycle, the lowest-numbered port is granted and the others get code 11 with the busy flag at 0 (same-cycle collision).
- R7: Priority is fixed: a requesting port never loses to a higher-numbered port.
- R8: A single port that steps its address by stride S and always requests achieves a grant rate of 1/5 for S mod 32 = 0, 2/5 for 16, 4/5 for 8 and 24, and 1 for all other residues.
- R9: The stall output equals request and not grant. A granted or idle port shows code 00 and busy flag 0. The busy flag is 1 only together with code 11.
- R10: After reset all bank and subsection timers are clear, so the first request is granted.
- R11: Section and subsection rules never act between ports with different processor tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NPORT | Request per port |
| cpu_i | input | NPORT*CPU_W | Processor tag per port |
| addr_i | input | NPORT*BANK_W | Interleave field (low address bits) per port |
| gnt_o | output | NPORT | Access granted this cycle |
| stall_o | output | NPORT | Request refused this cycle |
| code_o | output | 2*NPORT | Conflict class per port: 00 none, 01 section, 10 subsection, 11 bank |
| busy_flag_o | output | NPORT | With code 11: 1 bank still busy, 0 same-cycle bank collision |

## Verification
Two checks can apply to the same port in the same cycle. The subsection reservation left by a sibling port and the recovery timer of the bank that sibling just used both apply when a port asks for the very same bank one cycle after its sibling was granted. The bench sets up that case directly and expects code 10 rather than 11 for all four refused cycles, then a grant in the fifth. A second case also gives two reasons at once: a same-cycle collision followed by the loser's retry. That retry must change from the collision form to the busy form of the bank code.

// File: rtl/bca_pkg.sv
package bca_pkg;

  typedef enum logic [1:0] {
    CF_NONE = 2'b00,
    CF_SECT = 2'b01,
    CF_SUBS = 2'b10,
    CF_BANK = 2'b11
  } conflict_e;

endpackage

// File: rtl/bca_addr_decode.sv
module bca_addr_decode #(
  parameter int BANK_W = 5,
  parameter int SUB_W  = 2,
  parameter int SEC_W  = 1
) (
  input  logic [BANK_W-1:0] field_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic [SEC_W-1:0]  sec_o
);

  // subsection and section are the top bits of the bank index
  assign bank_o = field_i;
  assign sub_o  = field_i[BANK_W-1 -: SUB_W];
  assign sec_o  = field_i[BANK_W-1 -: SEC_W];

endmodule

// File: rtl/bca_bank_timer.sv
module bca_bank_timer #(
  parameter int NPORT  = 4,
  parameter int BANK_W = 5,
  parameter int LOAD   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              gnt_i,
  input  logic [NPORT-1:0][BANK_W-1:0]  bank_i,
  output logic [(1<<BANK_W)-1:0]        busy_o
);

  localparam int NBANK = 1 << BANK_W;
  localparam int CNT_W = $clog2(LOAD + 1);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             hit;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
      hit = 1'b0;
      for (int p = 0; p < NPORT; p++) begin
        if (gnt_i[p] && (bank_i[p] == BANK_W'(b))) hit = 1'b1;
      end
    end

    always_comb begin
      cnt_d = cnt_q;
      if (hit)               cnt_d = CNT_W'(LOAD);
      else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign busy_o[b] = (cnt_q != '0);
  end

endmodule

// File: rtl/bca_sub_tracker.sv
module bca_sub_tracker #(
  parameter int NPORT  = 4,
  parameter int CPU_W  = 1,
  parameter int SUB_W  = 2,
  parameter int PORT_W = 2,
  parameter int LOAD   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             gnt_i,
  input  logic [NPORT-1:0][CPU_W-1:0]  cpu_i,
  input  logic [NPORT-1:0][SUB_W-1:0]  sub_i,
  output logic [NPORT-1:0]             blocked_o
);

  localparam int IDX_W = CPU_W + SUB_W;
  localparam int NENT  = 1 << IDX_W;
  localparam int CNT_W = $clog2(LOAD + 1);

  logic [NENT-1:0][CNT_W-1:0]  cnt_v;
  logic [NENT-1:0][PORT_W-1:0] own_v;

  // one reservation entry per (processor, subsection)
  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic              hit;
    logic [PORT_W-1:0] own_d, own_q;
    logic [CNT_W-1:0]  cnt_d, cnt_q;

    always_comb begin
      hit   = 1'b0;
      own_d = own_q;
      for (int p = 0; p < NPORT; p++) begin
        if (gnt_i[p] && ({cpu_i[p], sub_i[p]} == IDX_W'(e))) begin
          hit   = 1'b1;
          own_d = PORT_W'(p);
        end
      end
    end

    always_comb begin
      cnt_d = cnt_q;
      if (hit)              cnt_d = CNT_W'(LOAD);
      else if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        own_q <= '0;
      end else begin
        cnt_q <= cnt_d;
        if (hit) own_q <= own_d;
      end
    end

    assign cnt_v[e] = cnt_q;
    assign own_v[e] = own_q;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [IDX_W-1:0] ix;
    assign ix           = {cpu_i[p], sub_i[p]};
    assign blocked_o[p] = (cnt_v[ix] != '0) && (own_v[ix] != PORT_W'(p));
  end

endmodule

// File: rtl/bca_resolve.sv
module bca_resolve
  import bca_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int CPU_W  = 1,
  parameter int BANK_W = 5,
  parameter int SEC_W  = 1
) (
  input  logic [NPORT-1:0]              req_i,
  input  logic [NPORT-1:0][CPU_W-1:0]   cpu_i,
  input  logic [NPORT-1:0][BANK_W-1:0]  bank_i,
  input  logic [NPORT-1:0][SEC_W-1:0]   sec_i,
  input  logic [(1<<BANK_W)-1:0]        bank_busy_i,
  input  logic [NPORT-1:0]              sub_blocked_i,
  output logic [NPORT-1:0]              gnt_o,
  output logic [NPORT-1:0][1:0]         code_o,
  output logic [NPORT-1:0]              flag_o
);

  logic [NPORT-1:0] sect_v, simul_v;

  // a lower-numbered requester wins any same-cycle clash
  always_comb begin
    sect_v  = '0;
    simul_v = '0;
    for (int p = 0; p < NPORT; p++) begin
      for (int q = 0; q < NPORT; q++) begin
        if ((q < p) && req_i[q]) begin
          if ((cpu_i[q] == cpu_i[p]) && (sec_i[q] == sec_i[p])) sect_v[p]  = 1'b1;
          if (bank_i[q] == bank_i[p])                           simul_v[p] = 1'b1;
        end
      end
    end
  end

  // order: section, subsection, bank busy, bank collision
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      gnt_o[p]  = 1'b0;
      code_o[p] = CF_NONE;
      flag_o[p] = 1'b0;
      if (req_i[p]) begin
        if (sect_v[p]) begin
          code_o[p] = CF_SECT;
        end else if (sub_blocked_i[p]) begin
          code_o[p] = CF_SUBS;
        end else if (bank_busy_i[bank_i[p]]) begin
          code_o[p] = CF_BANK;
          flag_o[p] = 1'b1;
        end else if (simul_v[p]) begin
          code_o[p] = CF_BANK;
        end else begin
          gnt_o[p]  = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bank_conflict_arbiter.sv
module bank_conflict_arbiter #(
  parameter int NPORT     = 4,
  parameter int NCPU      = 2,
  parameter int BANK_W    = 5,
  parameter int SUB_W     = 2,
  parameter int SEC_W     = 1,
  parameter int BANK_LOAD = 4,
  parameter int SUB_LOAD  = 4,
  localparam int CPU_W    = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          req_i,
  input  logic [NPORT*CPU_W-1:0]    cpu_i,
  input  logic [NPORT*BANK_W-1:0]   addr_i,
  output logic [NPORT-1:0]          gnt_o,
  output logic [NPORT-1:0]          stall_o,
  output logic [2*NPORT-1:0]        code_o,
  output logic [NPORT-1:0]          busy_flag_o
);

  localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [NPORT-1:0][CPU_W-1:0]  cpu;
  logic [NPORT-1:0][BANK_W-1:0] bank;
  logic [NPORT-1:0][SUB_W-1:0]  sub;
  logic [NPORT-1:0][SEC_W-1:0]  sec;
  logic [NPORT-1:0][1:0]        code;
  logic [(1<<BANK_W)-1:0]       bank_busy;
  logic [NPORT-1:0]             sub_blocked;
  logic [NPORT-1:0]             gnt;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign cpu[p] = cpu_i[p*CPU_W +: CPU_W];

    bca_addr_decode #(.BANK_W(BANK_W), .SUB_W(SUB_W), .SEC_W(SEC_W)) u_dec (
      .field_i (addr_i[p*BANK_W +: BANK_W]),
      .bank_o  (bank[p]),
      .sub_o   (sub[p]),
      .sec_o   (sec[p])
    );

    assign code_o[2*p +: 2] = code[p];
  end

  bca_bank_timer #(.NPORT(NPORT), .BANK_W(BANK_W), .LOAD(BANK_LOAD)) u_banks (
    .clk    (clk),
    .rst_n  (rst_n),
    .gnt_i  (gnt),
    .bank_i (bank),
    .busy_o (bank_busy)
  );

  bca_sub_tracker #(.NPORT(NPORT), .CPU_W(CPU_W), .SUB_W(SUB_W),
                    .PORT_W(PORT_W), .LOAD(SUB_LOAD)) u_subs (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_i     (gnt),
    .cpu_i     (cpu),
    .sub_i     (sub),
    .blocked_o (sub_blocked)
  );

  bca_resolve #(.NPORT(NPORT), .CPU_W(CPU_W), .BANK_W(BANK_W), .SEC_W(SEC_W)) u_res (
    .req_i         (req_i),
    .cpu_i         (cpu),
    .bank_i        (bank),
    .sec_i         (sec),
    .bank_busy_i   (bank_busy),
    .sub_blocked_i (sub_blocked),
    .gnt_o         (gnt),
    .code_o        (code),
    .flag_o        (busy_flag_o)
  );

  assign gnt_o   = gnt;
  assign stall_o = req_i & ~gnt;

endmodule

// File: rtl/bank_conflict_arbiter_chk.sv
module bank_conflict_arbiter_chk #(
  parameter int NPORT  = 4,
  parameter int NCPU   = 2,
  parameter int BANK_W = 5,
  parameter int SEC_W  = 1,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPORT-1:0]        req_i,
  input logic [NPORT*CPU_W-1:0]  cpu_i,
  input logic [NPORT*BANK_W-1:0] addr_i,
  input logic [NPORT-1:0]        gnt_o,
  input logic [NPORT-1:0]        stall_o,
  input logic [2*NPORT-1:0]      code_o,
  input logic [NPORT-1:0]        busy_flag_o
);

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_o[p] |-> req_i[p]); // R9
    AST_STALL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o[p] |-> (code_o[2*p +: 2] != 2'b00) && !gnt_o[p]); // R9
    AST_GNT_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_o[p] |-> (code_o[2*p +: 2] == 2'b00) && !busy_flag_o[p]); // R9
    AST_FLAG_IS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      busy_flag_o[p] |-> (code_o[2*p +: 2] == 2'b11)); // R5

    for (genvar q = 0; q < NPORT; q++) begin : g_q
      AST_BANK_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_o[p] |=> !(gnt_o[q] &&
          (addr_i[q*BANK_W +: BANK_W] == $past(addr_i[p*BANK_W +: BANK_W])))); // R5

      if (p < q) begin : g_pair
        AST_BANK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
          !(gnt_o[p] && gnt_o[q] &&
            (addr_i[p*BANK_W +: BANK_W] == addr_i[q*BANK_W +: BANK_W]))); // R6
        AST_SECT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
          !(gnt_o[p] && gnt_o[q] &&
            (cpu_i[p*CPU_W +: CPU_W] == cpu_i[q*CPU_W +: CPU_W]) &&
            (addr_i[p*BANK_W+BANK_W-SEC_W +: SEC_W] ==
             addr_i[q*BANK_W+BANK_W-SEC_W +: SEC_W]))); // R2
        AST_LOW_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
          !(req_i[p] && gnt_o[q] &&
            (addr_i[p*BANK_W +: BANK_W] == addr_i[q*BANK_W +: BANK_W]))); // R7
      end
    end
  end

endmodule

bind bank_conflict_arbiter bank_conflict_arbiter_chk #(
  .NPORT(NPORT), .NCPU(NCPU), .BANK_W(BANK_W), .SEC_W(SEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .cpu_i       (cpu_i),
  .addr_i      (addr_i),
  .gnt_o       (gnt_o),
  .stall_o     (stall_o),
  .code_o      (code_o),
  .busy_flag_o (busy_flag_o)
);

// File: tb/sim_bank_conflict_arbiter.sv
module sim_bank_conflict_arbiter;

  localparam int NP = 4;
  localparam int BW = 5;

  logic           clk;
  logic           rst_n;
  logic [NP-1:0]  req_i;
  logic [NP-1:0]  cpu_i;
  logic [NP*BW-1:0] addr_i;
  logic [NP-1:0]  gnt_o, stall_o, busy_flag_o;
  logic [2*NP-1:0] code_o;

  logic        r [NP];
  logic        c [NP];
  logic [15:0] a [NP];

  int checks = 0;
  int errors = 0;

  bank_conflict_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cpu_i(cpu_i), .addr_i(addr_i),
    .gnt_o(gnt_o), .stall_o(stall_o), .code_o(code_o), .busy_flag_o(busy_flag_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      req_i[p]          = r[p];
      cpu_i[p]          = c[p];
      addr_i[p*BW +: BW] = a[p][BW-1:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int code_of(int p);
    return int'(code_o[2*p +: 2]);
  endfunction

  task automatic set_port(input int p, input bit rq, input bit cp, input int ad);
    r[p] = rq; c[p] = cp; a[p] = 16'(ad);
  endtask

  task automatic clear_all();
    for (int p = 0; p < NP; p++) set_port(p, 1'b0, 1'b0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clear_all();
    end
  endtask

  // called right after inputs are driven at a negedge
  task automatic wait_grant(input int p, input int ecode, input int eflag,
                            output int stalls, output int bad);
    stalls = 0; bad = 0;
    for (int k = 0; k < 12; k++) begin
      #1;
      if (gnt_o[p]) return;
      stalls++;
      if (code_of(p) != ecode || busy_flag_o[p] != eflag[0]) bad++;
      @(negedge clk);
    end
  endtask

  function automatic int gcd32(int s);
    int x, y, t;
    x = 32; y = s;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  initial begin
    int st, bad;
    clear_all();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(gnt_o == 0 && stall_o == 0 && code_o == 0 && busy_flag_o == 0,
        "R10 idle outputs in reset", int'(code_o), 0);
    rst_n = 1'b1;
    idle(2);

    // R10: first request after reset is granted
    @(negedge clk); set_port(0, 1, 0, 0); #1;
    chk(gnt_o[0] == 1'b1, "R10 first grant", int'(gnt_o[0]), 1);
    idle(6);

    // R2: same cpu, same section -> port1 section conflict
    @(negedge clk); set_port(0, 1, 0, 0); set_port(1, 1, 0, 3); #1;
    chk(gnt_o[0] && code_of(1) == 1 && stall_o[1], "R2 section clash code", code_of(1), 1);
    idle(6);
    // R2/R1: different sections both granted
    @(negedge clk); set_port(0, 1, 0, 0); set_port(1, 1, 0, 16); #1;
    chk(gnt_o[1:0] == 2'b11, "R2 distinct sections", int'(gnt_o[1:0]), 3);
    idle(6);
    // R1: upper address bits ignored (0 and 0x20 decode to same bank/section)
    @(negedge clk); set_port(0, 1, 0, 0); set_port(1, 1, 0, 32); #1;
    chk(gnt_o[0] && code_of(1) == 1, "R1 high bits ignored", code_of(1), 1);
    idle(6);

    // R3: subsection reservation, 4 stalls with code 10
    @(negedge clk); set_port(0, 1, 0, 0); #1;
    chk(gnt_o[0] == 1'b1, "R3 reserving grant", int'(gnt_o[0]), 1);
    @(negedge clk); clear_all(); set_port(1, 1, 0, 1);
    wait_grant(1, 2, 0, st, bad);
    chk(st == 4, "R3 subsection stall count", st, 4);
    chk(bad == 0, "R3 subsection code", bad, 0);
    idle(6);

    // R4: subsection beats bank busy (same bank)
    @(negedge clk); set_port(0, 1, 0, 0);
    @(negedge clk); clear_all(); set_port(1, 1, 0, 0);
    wait_grant(1, 2, 0, st, bad);
    chk(st == 4 && bad == 0, "R4 precedence code 10", bad, 0);
    idle(6);

    // R5: bank busy across cpus
    @(negedge clk); set_port(0, 1, 0, 0);
    @(negedge clk); clear_all(); set_port(2, 1, 1, 0);
    wait_grant(2, 3, 1, st, bad);
    chk(st == 4, "R5 bank busy stall count", st, 4);
    chk(bad == 0, "R5 bank busy code/flag", bad, 0);
    idle(6);

    // R11: other cpu ignores subsection reservation and section rule
    @(negedge clk); set_port(0, 1, 0, 0);
    @(negedge clk); clear_all(); set_port(2, 1, 1, 1); #1;
    chk(gnt_o[2] == 1'b1, "R11 cross-cpu subsection", int'(gnt_o[2]), 1);
    idle(6);
    @(negedge clk); set_port(0, 1, 0, 0); set_port(2, 1, 1, 1); #1;
    chk(gnt_o[0] && gnt_o[2], "R11 cross-cpu section", int'(gnt_o), 5);
    idle(6);

    // R6: simultaneous bank, then busy on retry
    @(negedge clk); set_port(0, 1, 0, 5); set_port(2, 1, 1, 5); #1;
    chk(gnt_o[0] && code_of(2) == 3 && !busy_flag_o[2], "R6 simultaneous flag 0",
        int'(busy_flag_o[2]), 0);
    @(negedge clk); set_port(0, 0, 0, 0); #1;
    chk(code_of(2) == 3 && busy_flag_o[2], "R6 retry turns busy", int'(busy_flag_o[2]), 1);
    idle(6);

    // R7: lowest port wins bank and section clashes
    @(negedge clk); set_port(1, 1, 0, 7); set_port(3, 1, 1, 7); #1;
    chk(gnt_o[1] && !gnt_o[3] && code_of(3) == 3, "R7 bank priority", int'(gnt_o), 2);
    idle(6);
    @(negedge clk); set_port(0, 1, 1, 2); set_port(3, 1, 1, 9); #1;
    chk(gnt_o[0] && code_of(3) == 1, "R7 section priority", code_of(3), 1);
    idle(6);

    // R8/R9: stride sweep on port 0
    for (int s = 0; s < 32; s++) begin
      int grants, badc, badst, nb, expg;
      int addr;
      idle(6);
      grants = 0; badc = 0; badst = 0; addr = 0;
      for (int t = 0; t < 200; t++) begin
        @(negedge clk);
        set_port(0, 1, 0, addr);
        #1;
        if (stall_o[0] == gnt_o[0]) badst++;
        if (gnt_o[0]) begin
          grants++;
          addr = addr + s;
        end else if (code_of(0) != 3 || !busy_flag_o[0]) badc++;
      end
      nb   = (s == 0) ? 1 : 32 / gcd32(s);
      expg = (nb >= 5) ? 200 : 40 * nb;
      chk(grants == expg, $sformatf("R8 stride %0d grant count", s), grants, expg);
      chk(badc == 0 && badst == 0, $sformatf("R9 stride %0d stall outputs", s),
          badc + badst, 0);
    end
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule